// File: doc/BRIEF.md
# Double-SHA-256 Nonce Search Core

This block searches a contiguous range of 32-bit nonces for proof-of-work winners. A job gives it a 256-bit chaining state that already covers the first 64 header bytes, the three header words that come before the nonce, a 256-bit target, and the first and last nonce of the range. For each nonce, the block builds the padded second message block and compresses it starting from the supplied chaining state. It then hashes the resulting 32-byte digest once more, starting from the standard initial values, and compares the final hash with the target.

A single round engine runs one compression round per clock and serves both passes. Each nonce takes 132 cycles when it is not a hit. A nonce that meets the target is offered on a valid/ready result port. The search stalls until that result is taken, so no winner is dropped. Loading a new job at any time abandons the current one.

Top module: `nonce_search_core`

## Requirements
- R1: First pass. The message block words are W0..W2 = `job_tail[95:64]`, `job_tail[63:32]`, `job_tail[31:0]`. W3 is the nonce with its bytes swapped. W4 = 0x80000000, W5..W14 = 0 and W15 = 640. The compression starts from `job_midstate`, with word A in bits 255:224. Its digest is the round output added word by word to that midstate.
- R2: Second pass. The message block words are the eight first-pass digest words, then W8 = 0x80000000, W9..W14 = 0 and W15 = 256. It starts from the standard SHA-256 initial values. `res_hash` carries the final digest, with its word 0 in bits 255:224.
- R3: A nonce is a hit only when the final digest, read as an unsigned number, is strictly below `job_target`. For this comparison, digest byte 0 (bits 255:248 of `res_hash`) is the least significant byte. A hash equal to the target is not a hit.
- R4: Nonces run from `job_first` to `job_last` inclusive, in ascending order. A range with `job_first == job_last` searches exactly one nonce. Hits appear on the result port in nonce order, and each hit is transferred exactly once.
- R5: After the last nonce has been evaluated and any hit from it has been taken, `done` goes to 1 and `busy` goes to 0. Both stay that way, with no further results, until the next job load.
- R6: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_nonce` and `res_hash` hold steady and the search does not advance.
- R7: A `job_load` pulse in any state aborts the current search. It clears any pending result and `done`, and starts the new range from its first nonce. The new job's results are correct and no result from the old job appears afterwards.
- R8: After reset, `res_valid`, `done` and `busy` are 0.
- R9: A job whose target is zero produces no results and still completes with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_load | input | 1 | One-cycle pulse that captures a new job |
| job_midstate | input | 256 | Chaining state after header bytes 0..63 |
| job_tail | input | 96 | Three header words preceding the nonce |
| job_target | input | 256 | Hit threshold |
| job_first | input | 32 | First nonce of the range |
| job_last | input | 32 | Last nonce of the range (inclusive) |
| busy | output | 1 | Search in progress |
| done | output | 1 | Range finished |
| res_valid | output | 1 | Hit result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_nonce | output | 32 | Nonce of the hit |
| res_hash | output | 256 | Final double-hash digest of the hit |

## Verification
Two events can fall in the same cycle: a held hit waiting on `res_ready`, and a new job load. The bench provokes this by holding ready low until a hit is parked, then pulsing `job_load`. It expects the pending result to vanish on the next cycle, and only the new job's winners, in order, once ready is raised. Expected digests come from a bench-side SHA-256 model. That model's constants are derived from the roots of primes and are confirmed against a known digest. Targets are set exactly at, and one above, a computed hash to pin down the strict comparison and the byte order.

// File: rtl/nonce_search_core.sv
module nonce_search_core (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         job_load,
  input  logic [255:0] job_midstate,
  input  logic [95:0]  job_tail,
  input  logic [255:0] job_target,
  input  logic [31:0]  job_first,
  input  logic [31:0]  job_last,
  output logic         busy,
  output logic         done,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [31:0]  res_nonce,
  output logic [255:0] res_hash
);

  localparam logic [255:0] IV = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                 32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_ROUND, S_FOLD, S_HOLD, S_NEXT} state_t;

  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] kconst(input logic [5:0] i);
    case (i)
      6'd0:  return 32'h428a2f98; 6'd1:  return 32'h71374491;
      6'd2:  return 32'hb5c0fbcf; 6'd3:  return 32'he9b5dba5;
      6'd4:  return 32'h3956c25b; 6'd5:  return 32'h59f111f1;
      6'd6:  return 32'h923f82a4; 6'd7:  return 32'hab1c5ed5;
      6'd8:  return 32'hd807aa98; 6'd9:  return 32'h12835b01;
      6'd10: return 32'h243185be; 6'd11: return 32'h550c7dc3;
      6'd12: return 32'h72be5d74; 6'd13: return 32'h80deb1fe;
      6'd14: return 32'h9bdc06a7; 6'd15: return 32'hc19bf174;
      6'd16: return 32'he49b69c1; 6'd17: return 32'hefbe4786;
      6'd18: return 32'h0fc19dc6; 6'd19: return 32'h240ca1cc;
      6'd20: return 32'h2de92c6f; 6'd21: return 32'h4a7484aa;
      6'd22: return 32'h5cb0a9dc; 6'd23: return 32'h76f988da;
      6'd24: return 32'h983e5152; 6'd25: return 32'ha831c66d;
      6'd26: return 32'hb00327c8; 6'd27: return 32'hbf597fc7;
      6'd28: return 32'hc6e00bf3; 6'd29: return 32'hd5a79147;
      6'd30: return 32'h06ca6351; 6'd31: return 32'h14292967;
      6'd32: return 32'h27b70a85; 6'd33: return 32'h2e1b2138;
      6'd34: return 32'h4d2c6dfc; 6'd35: return 32'h53380d13;
      6'd36: return 32'h650a7354; 6'd37: return 32'h766a0abb;
      6'd38: return 32'h81c2c92e; 6'd39: return 32'h92722c85;
      6'd40: return 32'ha2bfe8a1; 6'd41: return 32'ha81a664b;
      6'd42: return 32'hc24b8b70; 6'd43: return 32'hc76c51a3;
      6'd44: return 32'hd192e819; 6'd45: return 32'hd6990624;
      6'd46: return 32'hf40e3585; 6'd47: return 32'h106aa070;
      6'd48: return 32'h19a4c116; 6'd49: return 32'h1e376c08;
      6'd50: return 32'h2748774c; 6'd51: return 32'h34b0bcb5;
      6'd52: return 32'h391c0cb3; 6'd53: return 32'h4ed8aa4a;
      6'd54: return 32'h5b9cca4f; 6'd55: return 32'h682e6ff3;
      6'd56: return 32'h748f82ee; 6'd57: return 32'h78a5636f;
      6'd58: return 32'h84c87814; 6'd59: return 32'h8cc70208;
      6'd60: return 32'h90befffa; 6'd61: return 32'ha4506ceb;
      6'd62: return 32'hbef9a3f7; default: return 32'hc67178f2;
    endcase
  endfunction

  state_t         state;
  logic [31:0]    v [8];
  logic [31:0]    w [16];
  logic [5:0]     rnd;
  logic           second;
  logic [255:0]   mid_q, tgt_q;
  logic [95:0]    tail_q;
  logic [31:0]    cur, last_q;

  logic [31:0]    t1, t2, wnext;
  logic [255:0]   fold_bus, hval, chain, blk_state;
  logic [511:0]   blk1, blk2, blk_msg;
  logic           hit;

  assign busy = (state != S_IDLE);

  always_comb begin
    t1 = v[7] + (ror(v[4], 6) ^ ror(v[4], 11) ^ ror(v[4], 25))
              + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kconst(rnd) + w[0];
    t2 = (ror(v[0], 2) ^ ror(v[0], 13) ^ ror(v[0], 22))
              + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
    wnext = (ror(w[14], 17) ^ ror(w[14], 19) ^ (w[14] >> 10)) + w[9]
          + (ror(w[1], 7) ^ ror(w[1], 18) ^ (w[1] >> 3)) + w[0];
  end

  assign chain = second ? IV : mid_q;

  always_comb begin
    for (int j = 0; j < 8; j++)
      fold_bus[255-32*j -: 32] = v[j] + chain[255-32*j -: 32];
    for (int b = 0; b < 32; b++)
      hval[8*b +: 8] = fold_bus[255-8*b -: 8];
  end

  assign hit  = (hval < tgt_q);
  assign blk1 = {tail_q, cur[7:0], cur[15:8], cur[23:16], cur[31:24],
                 32'h80000000, 320'd0, 32'd640};
  assign blk2 = {fold_bus, 32'h80000000, 192'd0, 32'd256};

  assign blk_msg   = (state == S_LOAD) ? blk1 : blk2;
  assign blk_state = (state == S_LOAD) ? mid_q : IV;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      done      <= 1'b0;
      res_valid <= 1'b0;
      res_nonce <= '0;
      res_hash  <= '0;
      rnd       <= '0;
      second    <= 1'b0;
    end else if (job_load) begin
      mid_q     <= job_midstate;
      tail_q    <= job_tail;
      tgt_q     <= job_target;
      cur       <= job_first;
      last_q    <= job_last;
      done      <= 1'b0;
      res_valid <= 1'b0;
      state     <= S_LOAD;
    end else begin
      case (state)
        S_LOAD: begin
          for (int j = 0; j < 8; j++)  v[j] <= blk_state[255-32*j -: 32];
          for (int j = 0; j < 16; j++) w[j] <= blk_msg[511-32*j -: 32];
          rnd    <= '0;
          second <= 1'b0;
          state  <= S_ROUND;
        end
        S_ROUND: begin
          v[0] <= t1 + t2;
          v[1] <= v[0];
          v[2] <= v[1];
          v[3] <= v[2];
          v[4] <= v[3] + t1;
          v[5] <= v[4];
          v[6] <= v[5];
          v[7] <= v[6];
          for (int j = 0; j < 15; j++) w[j] <= w[j+1];
          w[15] <= wnext;
          rnd   <= rnd + 6'd1;
          if (rnd == 6'd63) state <= S_FOLD;
        end
        S_FOLD: begin
          if (!second) begin
            for (int j = 0; j < 8; j++)  v[j] <= blk_state[255-32*j -: 32];
            for (int j = 0; j < 16; j++) w[j] <= blk_msg[511-32*j -: 32];
            rnd    <= '0;
            second <= 1'b1;
            state  <= S_ROUND;
          end else if (hit) begin
            res_valid <= 1'b1;
            res_nonce <= cur;
            res_hash  <= fold_bus;
            state     <= S_HOLD;
          end else begin
            state <= S_NEXT;
          end
        end
        S_HOLD: begin
          if (res_ready) begin
            res_valid <= 1'b0;
            state     <= S_NEXT;
          end
        end
        S_NEXT: begin
          if (cur == last_q) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            cur   <= cur + 32'd1;
            state <= S_LOAD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nonce_search_core_chk.sv
module nonce_search_core_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         job_load,
  input logic         busy,
  input logic         done,
  input logic         res_valid,
  input logic         res_ready,
  input logic [31:0]  res_nonce,
  input logic [255:0] res_hash
);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !job_load) |=>
      (res_valid && $stable(res_nonce) && $stable(res_hash)));

  assert_result_in_search_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (busy && !done));

  assert_load_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    job_load |=> (!res_valid && !done && busy));

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_single_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !job_load) |=> !res_valid);

  assert_done_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !job_load) |=> (done && !res_valid));

endmodule

bind nonce_search_core nonce_search_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .job_load(job_load), .busy(busy), .done(done),
  .res_valid(res_valid), .res_ready(res_ready), .res_nonce(res_nonce),
  .res_hash(res_hash)
);

// File: tb/sim_nonce_search_core.sv
module sim_nonce_search_core;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         job_load;
  logic [255:0] job_midstate;
  logic [95:0]  job_tail;
  logic [255:0] job_target;
  logic [31:0]  job_first, job_last;
  logic         busy, done, res_valid, res_ready;
  logic [31:0]  res_nonce;
  logic [255:0] res_hash;

  always #2 clk = ~clk;

  nonce_search_core u0 (
    .clk(clk), .rst_n(rst_n), .job_load(job_load), .job_midstate(job_midstate),
    .job_tail(job_tail), .job_target(job_target), .job_first(job_first),
    .job_last(job_last), .busy(busy), .done(done), .res_valid(res_valid),
    .res_ready(res_ready), .res_nonce(res_nonce), .res_hash(res_hash)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0]  KT [64];
  logic [255:0] HIV;
  logic [31:0]  got_n [64];
  logic [255:0] got_h [64];
  int           ncol = 0;

  always @(negedge clk)
    if (rst_n && res_valid && res_ready && ncol < 64) begin
      got_n[ncol] = res_nonce;
      got_h[ncol] = res_hash;
      ncol++;
    end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] mcomp(input logic [255:0] h, input logic [511:0] blk);
    logic [31:0] W [64];
    logic [31:0] s [8];
    logic [31:0] x1, x2;
    logic [255:0] r;
    for (int t = 0; t < 16; t++) W[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 64; t++)
      W[t] = (mr(W[t-2], 17) ^ mr(W[t-2], 19) ^ (W[t-2] >> 10)) + W[t-7]
           + (mr(W[t-15], 7) ^ mr(W[t-15], 18) ^ (W[t-15] >> 3)) + W[t-16];
    for (int j = 0; j < 8; j++) s[j] = h[255-32*j -: 32];
    for (int t = 0; t < 64; t++) begin
      x1 = s[7] + (mr(s[4], 6) ^ mr(s[4], 11) ^ mr(s[4], 25))
         + ((s[4] & s[5]) ^ (~s[4] & s[6])) + KT[t] + W[t];
      x2 = (mr(s[0], 2) ^ mr(s[0], 13) ^ mr(s[0], 22))
         + ((s[0] & s[1]) ^ (s[0] & s[2]) ^ (s[1] & s[2]));
      for (int j = 7; j > 0; j--) s[j] = s[j-1];
      s[4] = s[4] + x1;
      s[0] = x1 + x2;
    end
    for (int j = 0; j < 8; j++) r[255-32*j -: 32] = s[j] + h[255-32*j -: 32];
    return r;
  endfunction

  function automatic logic [255:0] mdouble(input logic [255:0] mid, input logic [95:0] tail,
                                           input logic [31:0] n);
    logic [511:0] b1;
    logic [255:0] d1;
    b1 = {tail, n[7:0], n[15:8], n[23:16], n[31:24], 32'h80000000, 320'd0, 32'd640};
    d1 = mcomp(mid, b1);
    return mcomp(HIV, {d1, 32'h80000000, 192'd0, 32'd256});
  endfunction

  function automatic logic [255:0] mval(input logic [255:0] d);
    logic [255:0] r;
    for (int b = 0; b < 32; b++) r[8*b +: 8] = d[255-8*b -: 8];
    return r;
  endfunction

  task automatic build_tables();
    int found = 0;
    int p = 2;
    real rr;
    longint lv;
    while (found < 64) begin
      bit prime = 1;
      for (int q = 2; q * q <= p; q++) if (p % q == 0) prime = 0;
      if (prime) begin
        rr = $pow(real'(p), 1.0 / 3.0);
        rr = rr - $floor(rr);
        lv = longint'($floor(rr * 4294967296.0));
        KT[found] = lv[31:0];
        if (found < 8) begin
          rr = $sqrt(real'(p));
          rr = rr - $floor(rr);
          lv = longint'($floor(rr * 4294967296.0));
          HIV[255-32*found -: 32] = lv[31:0];
        end
        found++;
      end
      p++;
    end
  endtask

  task automatic load(input logic [255:0] mid, input logic [95:0] tail, input logic [255:0] tgt,
                      input logic [31:0] first, input logic [31:0] last);
    @(posedge clk); #1;
    job_midstate = mid; job_tail = tail; job_target = tgt;
    job_first = first; job_last = last; job_load = 1'b1;
    @(posedge clk); #1;
    job_load = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!done && k < 40000) begin @(negedge clk); k++; end
    chk(done === 1'b1, req, "done after range", {255'd0, done}, 256'd1);
  endtask

  task automatic wait_valid(input string req);
    int k = 0;
    while (!res_valid && k < 2000) begin @(negedge clk); k++; end
    chk(res_valid === 1'b1, req, "hit offered", {255'd0, res_valid}, 256'd1);
  endtask

  task automatic compare_list(input string req, input logic [255:0] mid, input logic [95:0] tail,
                              input logic [255:0] tgt, input longint first, input longint last);
    int ne = 0;
    logic [31:0]  en [64];
    logic [255:0] eh [64];
    for (longint n = first; n <= last; n++) begin
      logic [255:0] d;
      d = mdouble(mid, tail, n[31:0]);
      if (mval(d) < tgt && ne < 64) begin en[ne] = n[31:0]; eh[ne] = d; ne++; end
    end
    chk(ncol == ne, req, "R4 hit count", 256'(ncol), 256'(ne));
    for (int i = 0; i < ne && i < ncol; i++) begin
      chk(got_n[i] == en[i], req, "R4 nonce order", {224'd0, got_n[i]}, {224'd0, en[i]});
      chk(got_h[i] == eh[i], req, "R1/R2 digest", got_h[i], eh[i]);
    end
  endtask

  task automatic run_job(input string req, input logic [255:0] mid, input logic [95:0] tail,
                         input logic [255:0] tgt, input logic [31:0] first, input logic [31:0] last);
    ncol = 0;
    load(mid, tail, tgt, first, last);
    wait_done(req);
    chk(busy === 1'b0, "R5", "busy low when done", {255'd0, busy}, 256'd0);
    compare_list(req, mid, tail, tgt, longint'(first), longint'(last));
    repeat (20) @(negedge clk);
    chk(done === 1'b1 && res_valid === 1'b0, "R5", "stays done, silent",
        {254'd0, done, res_valid}, 256'd2);
  endtask

  localparam logic [255:0] MA = 256'h1b2c3d4e_5f607182_93a4b5c6_d7e8f901_0a1b2c3d_4e5f6071_8293a4b5_c6d7e8f9;
  localparam logic [255:0] MB = 256'hdeadbeef_01234567_89abcdef_fedcba98_76543210_0f1e2d3c_4b5a6978_8796a5b4;
  localparam logic [95:0]  TA = 96'h4a5e1e4b_29ab5f49_ffff001d;
  localparam logic [95:0]  TB = 96'h11223344_55667788_99aabbcc;
  localparam logic [255:0] ONES = {256{1'b1}};

  initial begin
    logic [255:0] v777;
    rst_n = 1'b0; job_load = 1'b0; res_ready = 1'b1;
    job_midstate = '0; job_tail = '0; job_target = '0; job_first = '0; job_last = '0;
    build_tables();
    chk(mcomp(HIV, {32'h61626380, 448'd0, 32'h18}) ==
        256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad,
        "R2", "bench model known answer",
        mcomp(HIV, {32'h61626380, 448'd0, 32'h18}),
        256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid === 1'b0 && done === 1'b0 && busy === 1'b0, "R8", "reset outputs",
        {253'd0, res_valid, done, busy}, 256'd0);

    // R1 R2 R4: every nonce wins under an all-ones target
    run_job("R1", MA, TA, ONES, 32'd100, 32'd105);
    // R9: zero target gives nothing
    run_job("R9", MB, TB, 256'd0, 32'd0, 32'd5);
    // R3: exact-equal target misses, one above hits, single-nonce range
    v777 = mval(mdouble(MA, TA, 32'd777));
    run_job("R3", MA, TA, v777, 32'd777, 32'd777);
    run_job("R3", MA, TA, v777 + 256'd1, 32'd777, 32'd777);
    // R3 R4: sweeps with about half and a quarter winning, top of nonce space
    run_job("R3", MB, TA, 256'd1 << 255, 32'hFFFFFFF0, 32'hFFFFFFFF);
    run_job("R4", MA, TB, 256'd1 << 254, 32'd0, 32'd15);

    // R6: backpressure holds the result and stalls the search
    @(posedge clk); #1 res_ready = 1'b0;
    ncol = 0;
    load(MB, TB, ONES, 32'd200, 32'd202);
    wait_valid("R6");
    repeat (300) @(negedge clk);
    chk(res_valid === 1'b1 && res_nonce == 32'd200, "R6", "held nonce",
        {223'd0, res_valid, res_nonce}, {223'd0, 1'b1, 32'd200});
    chk(res_hash == mdouble(MB, TB, 32'd200), "R6", "held digest", res_hash, mdouble(MB, TB, 32'd200));
    chk(done === 1'b0 && busy === 1'b1, "R6", "search stalled", {254'd0, done, busy}, 256'd1);
    @(posedge clk); #1 res_ready = 1'b1;
    wait_done("R6");
    compare_list("R6", MB, TB, ONES, 200, 202);

    // R7: new job while a hit is pending
    @(posedge clk); #1 res_ready = 1'b0;
    ncol = 0;
    load(MA, TA, ONES, 32'd300, 32'd305);
    wait_valid("R7");
    load(MB, TA, 256'd1 << 255, 32'd50, 32'd57);
    @(negedge clk);
    chk(res_valid === 1'b0 && done === 1'b0, "R7", "pending result dropped",
        {254'd0, res_valid, done}, 256'd0);
    @(posedge clk); #1 res_ready = 1'b1;
    wait_done("R7");
    compare_list("R7", MB, TA, 256'd1 << 255, 50, 57);

    // R7: new job in the middle of a compression
    ncol = 0;
    load(MA, TB, ONES, 32'd400, 32'd410);
    repeat (70) @(negedge clk);
    ncol = 0;
    load(MA, TB, ONES, 32'd9, 32'd11);
    wait_done("R7");
    compare_list("R7", MA, TB, ONES, 9, 11);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule